// File: doc/BRIEF.md
# Vector Unpack and Mask Engine

This block takes a stream of 32-bit words and expands each group of packed elements into one 128-bit quadword of four 32-bit lanes. Each quadword is written to a destination memory through a read-modify-write port. A command pulse configures a run of vectors. The command selects the element width and the component count, and a cycle pair (CL, WL) controls write spacing. CL > WL skips destination slots. CL < WL inserts filler vectors that take no stream data.

Each lane can be taken from one of four sources under a 2-bit mask code:
- the unpacked element,
- a row register,
- a column register,
- the old memory contents, which inhibits the write for that lane.

After masking, a mode setting can add the row registers to every lane. In the accumulate mode the sums are also written back into the row registers. The engine works through a run one vector at a time. It gathers the stream words for a vector, reads the old quadword, and writes the new one to the same address. Mask, mode and column inputs are used live and must stay stable while the engine is busy.

Top module: `vu_unpack_engine`

## Requirements
- R1: On `start`, `cmd_i[1:0]` selects the element format: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = 5-5-5-1. `cmd_i[3:2]` is the component count minus one (vn). `cmd_i[4]` enables masking. Each non-filler vector begins on a fresh stream word and takes vn+1 words (32-bit), vn/2+1 words (16-bit), or one word (8-bit and 5-5-5-1). For 32-bit elements, lane i takes word i.
- R2: A `num_i` of 0 runs 256 vectors; any other value runs `num_i` vectors.
- R3: 16-bit and 8-bit elements are sign-extended to 32 bits. The low element within a word comes first: lane i takes half (i mod 2) of word i/2, or byte i of the single word.
- R4: The 5-5-5-1 format takes lanes 0..3 from bits 4:0, 9:5, 14:10 and 15 of the word, each sign-extended. Bits 31:16 are ignored.
- R5: Vector v is written to quadword address `base_i + CL*(v/WL) + (v mod WL)`, modulo 2^16. A `wl_i` of 0 means 256.
- R6: When CL < WL and (v mod WL) >= CL, vector v is a filler. Its unpacked lanes are zero and it consumes no stream words.
- R7: With masking on, lane i uses code `mask_i[8*r+2*i +: 2]`, where r = min(v mod WL, 3). The codes select:
  - 0: the unpacked lane
  - 1: row register lane i
  - 2: column register lane min(v,3)
  - 3: the old memory lane
  
  Without masking, every lane uses code 0. Row and column register lane i sits at bits [32i+31:32i].
- R8: When vn = 0, every lane that selects the unpacked input gets lane 0 of the unpacked data. When vn > 0, unpacked lanes above vn are zero.
- R9: `mode_i` selects the add stage:
  - 0 and 3: the masked value passes through unchanged.
  - 1: row register lane i is added to lane i, modulo 2^32.
  - 2: as mode 1, and each sum is also written into its row register.
  
  Row registers change only through accumulation or through `row_ld` while idle.
- R10: A start with format 3 and vn != 3 raises `err_fmt`, performs no write and consumes no word. It pulses `done` on the following cycle. `err_fmt` holds until the next start, which reloads it from that start's format check.
- R11: Each write follows a read of the same address on the previous cycle, and reads and writes never coincide. `s_ready` is high only while busy and waiting for a word. `done` pulses for one cycle after the last write.
- R12: After reset, `busy`, `done`, `err_fmt`, `s_ready` and both memory enables are low, and the row registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (sampled while idle) |
| cmd_i | input | 5 | Format, component count and mask enable |
| num_i | input | 8 | Vector count (0 = 256) |
| base_i | input | 10 | Destination base quadword address |
| cl_i | input | 8 | Cycle CL value |
| wl_i | input | 8 | Cycle WL value (0 = 256) |
| mask_i | input | 32 | Four rows of four 2-bit lane codes |
| mode_i | input | 2 | Add stage mode |
| col_i | input | 128 | Four column register words |
| row_ld | input | 1 | Load row registers while idle |
| row_ld_data | input | 128 | Row register load value |
| row_q | output | 128 | Current row registers |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word |
| s_ready | output | 1 | Stream word accepted when high with valid |
| mem_rd_en | output | 1 | Read old quadword |
| mem_wr_en | output | 1 | Write new quadword |
| mem_addr | output | 16 | Quadword address for read and write |
| mem_rd_data | input | 128 | Read data, one cycle after `mem_rd_en` |
| mem_wr_data | output | 128 | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_fmt | output | 1 | Unsupported format flag |

## Verification
The hardest case to reach from the ports combines three conditions in one run:
- a filler vector sits between consuming vectors,
- the single-component lane replication applies,
- every mask code is used.

If any filler vector consumed a word, every later vector would shift, so misaligned consumption would show in the data. The bench drives a masked scalar run with CL < WL over several WL blocks. Each mask row holds a different code mix, so every lane source is seen on both filler and data vectors. A second masked run uses CL > WL with the add mode to cover skipped addresses. A stream with gaps every other cycle proves the stall behaviour.

// File: rtl/vu_pkg.sv
package vu_pkg;
  localparam int LANES  = 4;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_GATH, ST_RD, ST_WR} vu_state_e;
  typedef enum logic [1:0] {EW_32 = 2'd0, EW_16 = 2'd1, EW_8 = 2'd2, EW_5551 = 2'd3} vu_ew_e;
  typedef enum logic [1:0] {MS_INPUT = 2'd0, MS_ROW = 2'd1, MS_COL = 2'd2, MS_OLD = 2'd3} vu_sel_e;
  typedef enum logic [1:0] {MD_PASS = 2'd0, MD_ADD = 2'd1, MD_ACC = 2'd2, MD_PASS3 = 2'd3} vu_mode_e;

  typedef logic [LANES-1:0][WORD_W-1:0] vu_qw_t;

  function automatic logic [2:0] words_per_vec(input logic [1:0] ew, input logic [1:0] vn);
    case (ew)
      EW_32:   return {1'b0, vn} + 3'd1;
      EW_16:   return {2'b00, vn[1]} + 3'd1;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic fmt_bad(input logic [1:0] ew, input logic [1:0] vn);
    return (ew == EW_5551) && (vn != 2'd3);
  endfunction

  function automatic logic [WORD_W-1:0] sx16(input logic [15:0] h);
    return {{16{h[15]}}, h};
  endfunction

  function automatic logic [WORD_W-1:0] sx8(input logic [7:0] b);
    return {{24{b[7]}}, b};
  endfunction

  function automatic logic [WORD_W-1:0] sx5(input logic [4:0] f);
    return {{27{f[4]}}, f};
  endfunction
endpackage

// File: rtl/vu_unpack.sv
module vu_unpack
  import vu_pkg::*;
(
  input  logic [1:0] ew,
  input  logic [1:0] vn,
  input  logic       fill,
  input  vu_qw_t     words,
  output vu_qw_t     lanes
);
  vu_qw_t raw;

  always_comb begin
    case (ew)
      EW_32: raw = words;
      EW_16: begin
        raw[0] = sx16(words[0][15:0]);
        raw[1] = sx16(words[0][31:16]);
        raw[2] = sx16(words[1][15:0]);
        raw[3] = sx16(words[1][31:16]);
      end
      EW_8: begin
        raw[0] = sx8(words[0][7:0]);
        raw[1] = sx8(words[0][15:8]);
        raw[2] = sx8(words[0][23:16]);
        raw[3] = sx8(words[0][31:24]);
      end
      default: begin
        raw[0] = sx5(words[0][4:0]);
        raw[1] = sx5(words[0][9:5]);
        raw[2] = sx5(words[0][14:10]);
        raw[3] = {WORD_W{words[0][15]}};
      end
    endcase
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (fill)                lanes[i] = '0;
      else if (vn == 2'd0)     lanes[i] = raw[0];
      else if (2'(i) > vn)     lanes[i] = '0;
      else                     lanes[i] = raw[i];
    end
  end
endmodule

// File: rtl/vu_lane_mix.sv
module vu_lane_mix
  import vu_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic              mask_en,
  input  logic [7:0]        mask_row,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] unp,
  input  logic [WORD_W-1:0] row,
  input  logic [WORD_W-1:0] col,
  input  logic [WORD_W-1:0] old,
  output logic [WORD_W-1:0] result
);
  logic [1:0]        code;
  logic [WORD_W-1:0] picked;

  assign code = mask_en ? mask_row[2*LANE +: 2] : MS_INPUT;

  always_comb begin
    case (vu_sel_e'(code))
      MS_INPUT: picked = unp;
      MS_ROW:   picked = row;
      MS_COL:   picked = col;
      default:  picked = old;
    endcase
  end

  always_comb begin
    if ((mode == MD_ADD) || (mode == MD_ACC)) result = picked + row;
    else                                      result = picked;
  end
endmodule

// File: rtl/vu_addr_gen.sv
module vu_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int BASE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              step,
  input  logic [BASE_W-1:0] base,
  input  logic [CNT_W-1:0]  cl,
  input  logic [CNT_W:0]    wl_eff,
  input  logic [CNT_W:0]    n_eff,
  output logic [ADDR_W-1:0] addr,
  output logic              fill,
  output logic              last,
  output logic [1:0]        row_idx,
  output logic [1:0]        col_idx
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0]  vcnt_q, vcnt_d, pos_q, pos_d;
  logic [ADDR_W-1:0] blk_q, blk_d;
  logic [EXT_W-1:0]  cl_ext;

  assign cl_ext = {1'b0, cl};

  always_comb begin
    vcnt_d = vcnt_q;
    pos_d  = pos_q;
    blk_d  = blk_q;
    if (init) begin
      vcnt_d = '0;
      pos_d  = '0;
      blk_d  = '0;
    end else if (step) begin
      vcnt_d = vcnt_q + 1'b1;
      if (pos_q == wl_eff - 1'b1) begin
        pos_d = '0;
        blk_d = blk_q + ADDR_W'(cl);
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt_q <= '0;
      pos_q  <= '0;
      blk_q  <= '0;
    end else if (init || step) begin
      vcnt_q <= vcnt_d;
      pos_q  <= pos_d;
      blk_q  <= blk_d;
    end
  end

  assign addr    = ADDR_W'(base) + blk_q + ADDR_W'(pos_q);
  assign fill    = (cl_ext < wl_eff) && (pos_q >= cl_ext);
  assign last    = (vcnt_q == n_eff - 1'b1);
  assign row_idx = (pos_q > EXT_W'(3)) ? 2'd3 : pos_q[1:0];
  assign col_idx = (vcnt_q > EXT_W'(3)) ? 2'd3 : vcnt_q[1:0];
endmodule

// File: rtl/vu_unpack_engine.sv
module vu_unpack_engine
  import vu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int BASE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [4:0]               cmd_i,
  input  logic [CNT_W-1:0]         num_i,
  input  logic [BASE_W-1:0]        base_i,
  input  logic [CNT_W-1:0]         cl_i,
  input  logic [CNT_W-1:0]         wl_i,
  input  logic [31:0]              mask_i,
  input  logic [1:0]               mode_i,
  input  logic [LANES*WORD_W-1:0]  col_i,
  input  logic                     row_ld,
  input  logic [LANES*WORD_W-1:0]  row_ld_data,
  output logic [LANES*WORD_W-1:0]  row_q,
  input  logic                     s_valid,
  input  logic [WORD_W-1:0]        s_data,
  output logic                     s_ready,
  output logic                     mem_rd_en,
  output logic                     mem_wr_en,
  output logic [ADDR_W-1:0]        mem_addr,
  input  logic [LANES*WORD_W-1:0]  mem_rd_data,
  output logic [LANES*WORD_W-1:0]  mem_wr_data,
  output logic                     busy,
  output logic                     done,
  output logic                     err_fmt
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic [EXT_W-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

  vu_state_e         state_q, state_d;
  logic [4:0]        cmd_q;
  logic [BASE_W-1:0] base_q;
  logic [CNT_W-1:0]  cl_q;
  logic [EXT_W-1:0]  wl_q, n_q;
  logic [1:0]        wcnt_q, wcnt_d;
  vu_qw_t            gw_q, gw_d;
  vu_qw_t            row_r, row_d;
  logic              row_en;
  logic              err_q, done_q;
  logic              err_d, done_d;

  logic        launch, bad_in, acc, last_word;
  logic [2:0]  wpv;
  logic        fill, last;
  logic [1:0]  row_idx, col_idx;
  vu_qw_t      unp, mix, col_a, old_a;

  assign bad_in    = fmt_bad(cmd_i[1:0], cmd_i[3:2]);
  assign launch    = (state_q == ST_IDLE) && start;
  assign wpv       = words_per_vec(cmd_q[1:0], cmd_q[3:2]);
  assign s_ready   = (state_q == ST_GATH) && !fill;
  assign acc       = s_valid && s_ready;
  assign last_word = ({1'b0, wcnt_q} == wpv - 3'd1);

  vu_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE_W(BASE_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (launch && !bad_in),
    .step    (state_q == ST_WR),
    .base    (base_q),
    .cl      (cl_q),
    .wl_eff  (wl_q),
    .n_eff   (n_q),
    .addr    (mem_addr),
    .fill    (fill),
    .last    (last),
    .row_idx (row_idx),
    .col_idx (col_idx)
  );

  vu_unpack u_unpack (
    .ew    (cmd_q[1:0]),
    .vn    (cmd_q[3:2]),
    .fill  (fill),
    .words (gw_q),
    .lanes (unp)
  );

  assign col_a = col_i;
  assign old_a = mem_rd_data;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vu_lane_mix #(.LANE(g)) u_mix (
      .mask_en  (cmd_q[4]),
      .mask_row (mask_i[8*row_idx +: 8]),
      .mode     (mode_i),
      .unp      (unp[g]),
      .row      (row_r[g]),
      .col      (col_a[col_idx]),
      .old      (old_a[g]),
      .result   (mix[g])
    );
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    gw_d    = gw_q;
    case (state_q)
      ST_IDLE: if (start && !bad_in) begin
        state_d = ST_GATH;
        wcnt_d  = '0;
      end
      ST_GATH: begin
        if (fill) state_d = ST_RD;
        else if (acc) begin
          gw_d[wcnt_q] = s_data;
          if (last_word) begin
            wcnt_d  = '0;
            state_d = ST_RD;
          end else begin
            wcnt_d = wcnt_q + 2'd1;
          end
        end
      end
      ST_RD:   state_d = ST_WR;
      default: state_d = last ? ST_IDLE : ST_GATH;
    endcase
  end

  always_comb begin
    row_d  = row_r;
    row_en = 1'b0;
    if ((state_q == ST_IDLE) && row_ld) begin
      row_d  = row_ld_data;
      row_en = 1'b1;
    end else if ((state_q == ST_WR) && (mode_i == MD_ACC)) begin
      row_d  = mix;
      row_en = 1'b1;
    end
  end

  assign done_d = ((state_q == ST_WR) && last) || (launch && bad_in);
  assign err_d  = launch ? bad_in : err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      base_q <= '0;
      cl_q   <= '0;
      wl_q   <= '0;
      n_q    <= '0;
    end else if (launch) begin
      cmd_q  <= cmd_i;
      base_q <= base_i;
      cl_q   <= cl_i;
      wl_q   <= (wl_i == '0) ? FULL_CNT : {1'b0, wl_i};
      n_q    <= (num_i == '0) ? FULL_CNT : {1'b0, num_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gw_q <= '0;
    else if (acc) gw_q <= gw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_r <= '0;
    else if (row_en) row_r <= row_d;
  end

  assign row_q       = row_r;
  assign mem_rd_en   = (state_q == ST_RD);
  assign mem_wr_en   = (state_q == ST_WR);
  assign mem_wr_data = mix;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err_fmt     = err_q;
endmodule

// File: rtl/vu_unpack_engine_chk.sv
module vu_unpack_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err_fmt,
  input logic              s_ready,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mode_i,
  input logic [127:0]      row_q
);
  a_r11_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));
  a_r11_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_addr == $past(mem_addr)));
  a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  a_r11_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_fmt |-> (!mem_wr_en && !s_ready));
  a_r9_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && ($past(mode_i) != 2'd2)) |-> $stable(row_q));
endmodule

bind vu_unpack_engine vu_unpack_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .err_fmt   (err_fmt),
  .s_ready   (s_ready),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .mem_addr  (mem_addr),
  .mode_i    (mode_i),
  .row_q     (row_q)
);

// File: tb/vu_unpack_engine_tb_top.sv
module vu_unpack_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [4:0]   cmd_i = '0;
  logic [7:0]   num_i = '0;
  logic [9:0]   base_i = '0;
  logic [7:0]   cl_i = '0;
  logic [7:0]   wl_i = '0;
  logic [31:0]  mask_i = '0;
  logic [1:0]   mode_i = '0;
  logic [127:0] col_i = '0;
  logic         row_ld = 1'b0;
  logic [127:0] row_ld_data = '0;
  logic [127:0] row_q;
  logic         s_valid = 1'b0;
  logic [31:0]  s_data = '0;
  logic         s_ready;
  logic         mem_rd_en, mem_wr_en;
  logic [15:0]  mem_addr;
  logic [127:0] mem_rd_data = '0;
  logic [127:0] mem_wr_data;
  logic         busy, done, err_fmt;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit gap = 1'b0;

  logic [31:0]  stream_q[$];
  logic [15:0]  exp_addr[$];
  logic [127:0] exp_data[$];
  logic [127:0] tb_mem[int];
  logic [127:0] ref_mem[int];
  logic [31:0]  ref_row[4];

  vu_unpack_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_i(cmd_i), .num_i(num_i),
    .base_i(base_i), .cl_i(cl_i), .wl_i(wl_i), .mask_i(mask_i), .mode_i(mode_i),
    .col_i(col_i), .row_ld(row_ld), .row_ld_data(row_ld_data), .row_q(row_q),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_data(mem_wr_data),
    .busy(busy), .done(done), .err_fmt(err_fmt)
  );

  always #5 clk = ~clk;

  function automatic logic [127:0] init_qw(input int a);
    logic [31:0] x;
    x = 32'(a);
    return {x * 32'd7 + 32'd3, x * 32'd5 + 32'd1, ~x, x ^ 32'h5A5A0000};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en) tb_mem[int'(mem_addr)] = mem_wr_data;
    if (mem_rd_en) mem_rd_data <= tb_mem.exists(int'(mem_addr)) ? tb_mem[int'(mem_addr)] : init_qw(int'(mem_addr));
  end

  // stream source
  always @(posedge clk) begin
    cyc++;
    if (s_valid && s_ready) void'(stream_q.pop_front());
  end
  always @(negedge clk) begin
    s_valid <= (stream_q.size() > 0) && !(gap && cyc[0]);
    s_data  <= (stream_q.size() > 0) ? stream_q[0] : 32'h0;
  end

  // per-clock comparison of writes against the reference
  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      if (exp_addr.size() == 0) chk(1'b0, "R11 unexpected write", {112'h0, mem_addr}, 128'h0);
      else begin
        chk(mem_addr == exp_addr[0], "R5 write address", {112'h0, mem_addr}, {112'h0, exp_addr[0]});
        chk(mem_wr_data == exp_data[0], "R1/R3/R4/R6/R7/R8/R9 write data", mem_wr_data, exp_data[0]);
        void'(exp_addr.pop_front());
        void'(exp_data.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic load_row(input logic [127:0] d);
    @(negedge clk);
    row_ld = 1'b1; row_ld_data = d;
    @(negedge clk);
    row_ld = 1'b0;
    for (int i = 0; i < 4; i++) ref_row[i] = d[32*i +: 32];
    chk(row_q == d, "R9 row load while idle", row_q, d);
  endtask

  task automatic run_cmd(input logic [4:0] c, input int nm, input int bs, input int cl, input int wl,
                         input logic [31:0] mk, input logic [1:0] md, input logic [127:0] cols, input string tag);
    int n, we, vn, vl, nw, a, pos, r, lim;
    bit bad, fl;
    logic [31:0] w[4];
    logic [31:0] raw[4];
    logic [31:0] u[4];
    logic [31:0] o[4];
    logic [127:0] old, q, rexp;
    logic [1:0] code;
    n  = (nm == 0) ? 256 : nm;
    we = (wl == 0) ? 256 : wl;
    vn = int'(c[3:2]);
    vl = int'(c[1:0]);
    bad = (vl == 3) && (vn != 3);
    if (!bad) begin
      for (int v = 0; v < n; v++) begin
        pos = v % we;
        fl  = (cl < we) && (pos >= cl);
        a   = (bs + cl * (v / we) + pos) & 16'hFFFF;
        for (int k = 0; k < 4; k++) w[k] = 32'h0;
        if (!fl) begin
          nw = (vl == 0) ? vn + 1 : (vl == 1) ? vn / 2 + 1 : 1;
          for (int k = 0; k < nw; k++) begin
            w[k] = $urandom;
            stream_q.push_back(w[k]);
          end
        end
        for (int i = 0; i < 4; i++) begin
          case (vl)
            0: raw[i] = w[i];
            1: raw[i] = 32'($signed(w[i / 2][16 * (i % 2) +: 16]));
            2: raw[i] = 32'($signed(w[0][8 * i +: 8]));
            default: raw[i] = (i == 0) ? 32'($signed(w[0][4:0])) :
                              (i == 1) ? 32'($signed(w[0][9:5])) :
                              (i == 2) ? 32'($signed(w[0][14:10])) : {32{w[0][15]}};
          endcase
        end
        for (int i = 0; i < 4; i++)
          u[i] = fl ? 32'h0 : (vn == 0) ? raw[0] : (i > vn) ? 32'h0 : raw[i];
        old = ref_mem.exists(a) ? ref_mem[a] : init_qw(a);
        r = (pos > 3) ? 3 : pos;
        for (int i = 0; i < 4; i++) begin
          code = c[4] ? mk[8 * r + 2 * i +: 2] : 2'd0;
          case (code)
            2'd0: o[i] = u[i];
            2'd1: o[i] = ref_row[i];
            2'd2: o[i] = cols[32 * ((v > 3) ? 3 : v) +: 32];
            default: o[i] = old[32 * i +: 32];
          endcase
          if (md == 2'd1 || md == 2'd2) o[i] = o[i] + ref_row[i];
          if (md == 2'd2) ref_row[i] = o[i];
        end
        q = {o[3], o[2], o[1], o[0]};
        ref_mem[a] = q;
        exp_addr.push_back(16'(a));
        exp_data.push_back(q);
      end
    end
    @(negedge clk);
    cmd_i = c; num_i = 8'(nm); base_i = 10'(bs); cl_i = 8'(cl); wl_i = 8'(wl);
    mask_i = mk; mode_i = md; col_i = cols; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lim = 0;
    while (!done && lim < 6000) begin
      @(negedge clk);
      lim++;
    end
    chk(done == 1'b1, {"R11 done pulse ", tag}, {127'h0, done}, 128'h1);
    chk(exp_addr.size() == 0, {"R2/R5 write count ", tag}, 128'(exp_addr.size()), 128'h0);
    chk(err_fmt == bad, {"R10 error flag ", tag}, {127'h0, err_fmt}, {127'h0, bad});
    rexp = {ref_row[3], ref_row[2], ref_row[1], ref_row[0]};
    chk(row_q == rexp, {"R9 row registers ", tag}, row_q, rexp);
    if (!bad) chk(stream_q.size() == 0, {"R1/R6 words consumed ", tag}, 128'(stream_q.size()), 128'h0);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) ref_row[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !err_fmt, "R12 status after reset", {125'h0, busy, done, err_fmt}, 128'h0);
    chk(!s_ready && !mem_rd_en && !mem_wr_en, "R12 ports after reset", {125'h0, s_ready, mem_rd_en, mem_wr_en}, 128'h0);
    chk(row_q == 128'h0, "R12 row registers after reset", row_q, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);

    load_row({32'h4000_0004, 32'hFFFF_FFF0, 32'h0000_0100, 32'h8000_0001});
    // R1 32-bit four components, pass-through
    run_cmd(5'b01100, 3, 16, 4, 4, 32'h0, 2'd0, 128'h0, "R1 v4x32");
    // R3 16-bit pairs with add mode and a gapped stream
    gap = 1'b1;
    run_cmd(5'b00101, 4, 40, 1, 1, 32'h0, 2'd1, 128'h0, "R3 v2x16 add");
    gap = 1'b0;
    run_cmd(5'b01001, 2, 60, 1, 1, 32'h0, 2'd0, 128'h0, "R3 v3x16");
    // R9 accumulate with 8-bit elements
    run_cmd(5'b01110, 3, 80, 1, 1, 32'h0, 2'd2, 128'h0, "R3 R9 v4x8 acc");
    // R4 5-5-5-1
    run_cmd(5'b01111, 3, 100, 2, 2, 32'h0, 2'd0, 128'h0, "R4 v4x5551");
    // R6 R7 R8 masked scalar with filler vectors
    run_cmd(5'b10000, 7, 200, 2, 4, 32'hE41B936C, 2'd0,
            {32'hC0C0_0003, 32'hC0C0_0002, 32'hC0C0_0001, 32'hC0C0_0000}, "R6 R7 R8 mask fill");
    // R5 R7 skipping writes, mask with add
    run_cmd(5'b11100, 5, 300, 4, 2, 32'h1BE44EB1, 2'd1,
            {32'h0000_0033, 32'h0000_0022, 32'h0000_0011, 32'h0000_0000}, "R5 R7 skip add");
    // R2 count of zero means 256
    run_cmd(5'b00010, 0, 500, 1, 1, 32'h0, 2'd0, 128'h0, "R2 num zero");
    // R5 R6 WL of zero means 256
    run_cmd(5'b00000, 3, 900, 1, 0, 32'h0, 2'd0, 128'h0, "R5 R6 wl zero");
    // R10 bad format leaves the stream untouched
    stream_q.push_back(32'hDEAD_BEEF);
    run_cmd(5'b00111, 2, 10, 1, 1, 32'h0, 2'd0, 128'h0, "R10 bad format");
    chk(stream_q.size() == 1, "R10 no word consumed", 128'(stream_q.size()), 128'h1);
    stream_q.delete();
    repeat (2) @(negedge clk);
    // R10 next valid start clears the flag
    run_cmd(5'b01100, 1, 20, 1, 1, 32'h0, 2'd3, 128'h0, "R10 clear R9 mode3");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule